// File: doc/BRIEF.md
# Peripheral Clock Enable Register Bank

This block holds one clock-enable bit per peripheral, for up to 64 peripherals, and drives those bits out as a vector. Downstream logic uses each bit to qualify its clock, for example as the enable input of its flops. The clock itself is never gated with logic. Software changes the bits through a simple synchronous register bus. Each group of 32 peripherals has three word registers: one turns bits on, one turns bits off, and one shows the current state. Writes to the first two touch only the bits written as 1. Because of this, different agents can switch their own peripherals without a read-modify-write sequence.

Peripheral identifiers 0 to 31 live in group 0, and identifiers 32 to 63 live in group 1. Within a group, identifier n maps to bit n modulo 32. The two lowest identifiers are hard-wired on. They cannot be switched off and always report as enabled.

Top module: `pclk_gate_bank`

## Requirements
- R1: Reset is synchronous and active high. After reset, `clk_en` has bits 0 and 1 set and every other bit clear, and `bus_rdata` is zero.
- R2: A write (`bus_we` high) to the enable register of a group sets every `clk_en` bit of that group whose `bus_wdata` bit is 1. The enable register of group 0 is at 0x00 and that of group 1 is at 0x10. The new value appears after the clock edge that takes the write. Bits written as 0 keep their value.
- R3: A write to the disable register of a group clears every `clk_en` bit of that group whose `bus_wdata` bit is 1. The disable register of group 0 is at 0x04 and that of group 1 is at 0x14. Bits written as 0 keep their value.
- R4: Reading the status register of a group returns that group's `clk_en` bits, with data bit n holding identifier 32*group+n. The status register of group 0 is at 0x08 and that of group 1 is at 0x18. `bus_rdata` is registered: it shows the state sampled at the edge where the address was presented, and it is valid after that edge.
- R5: Identifier 32+n is controlled by bit n of the group 1 registers. The group 0 registers never touch it.
- R6: Identifiers 0 and 1 are always enabled. Writes to their bits have no effect, and their status bits always read 1.
- R7: Reads of the enable registers, the disable registers, offsets 0x0C and 0x1C, and any address with a bit above bit 4 set return zero. Writes to those last three kinds of address change nothing. Address bits 1:0 are ignored.
- R8: While `bus_we` is low, no `clk_en` bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| clk_en | output | 64 | Per-peripheral clock-enable qualifiers, bit i for identifier i |

## Verification
The assertions assume that the bus presents at most one access per cycle and that address and write data are stable across each sampling edge. Under these assumptions a single cycle can never both set and clear the same bit. They also assume that reset is held for at least one edge before any access. The stimulus drives every input on the falling clock edge. It mixes random writes to both groups with writes and reads to unmapped and alias addresses, and it reads both status registers after every write.

// File: rtl/pclk_gate_pkg.sv
package pclk_gate_pkg;
  // register kind, taken from address bits [3:2]
  typedef enum logic [1:0] {
    KIND_SET  = 2'd0,
    KIND_CLR  = 2'd1,
    KIND_STAT = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  localparam int KIND_LSB = 2;
  localparam int GRP_LSB  = 4;

  function automatic int grp_count(input int n_periph, input int w);
    return (n_periph + w - 1) / w;
  endfunction
endpackage

// File: rtl/pclk_gate_decode.sv
module pclk_gate_decode
  import pclk_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NGRP   = 2,
  parameter int GIDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic [NGRP-1:0]   set_grp,
  output logic [NGRP-1:0]   clr_grp,
  output logic              stat_hit,
  output logic [GIDX_W-1:0] stat_grp
);
  localparam int TOP_LSB = GRP_LSB + GIDX_W;

  reg_kind_e         kind;
  logic [GIDX_W-1:0] gidx;
  logic              upper_clear;
  logic              grp_ok;

  always_comb begin
    kind        = reg_kind_e'(addr[KIND_LSB +: 2]);
    gidx        = addr[GRP_LSB +: GIDX_W];
    upper_clear = (ADDR_W > TOP_LSB) ? ((addr >> TOP_LSB) == '0) : 1'b1;
    grp_ok      = upper_clear && (int'(gidx) < NGRP);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_sel
    always_comb begin
      set_grp[g] = we && grp_ok && (int'(gidx) == g) && (kind == KIND_SET);
      clr_grp[g] = we && grp_ok && (int'(gidx) == g) && (kind == KIND_CLR);
    end
  end

  always_comb begin
    stat_hit = grp_ok && (kind == KIND_STAT);
    stat_grp = gidx;
  end
endmodule

// File: rtl/pclk_gate_slice.sv
module pclk_gate_slice #(
  parameter int W          = 32,
  parameter int BASE_ID    = 0,
  parameter int NUM_PERIPH = 64,
  parameter int NUM_RSVD   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] state
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int ID = BASE_ID + i;
    if (ID < NUM_RSVD) begin : g_fixed
      assign state[i] = 1'b1;
    end else if (ID >= NUM_PERIPH) begin : g_absent
      assign state[i] = 1'b0;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (rst)                      q <= 1'b0;
        else if (wr_clr && wdata[i])  q <= 1'b0;   // clear has priority
        else if (wr_set && wdata[i])  q <= 1'b1;
      end
      assign state[i] = q;

      p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wdata[i] && !wr_clr) |=> state[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wdata[i]) |=> !state[i]);
      p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !((wr_set || wr_clr) && wdata[i]) |=> $stable(state[i]));
    end
  end
endmodule

// File: rtl/pclk_gate_readback.sv
module pclk_gate_readback #(
  parameter int W      = 32,
  parameter int NGRP   = 2,
  parameter int GIDX_W = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stat_hit,
  input  logic [GIDX_W-1:0]        stat_grp,
  input  logic [NGRP-1:0][W-1:0]   grp_state,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int g = 0; g < NGRP; g++)
      if (stat_hit && int'(stat_grp) == g) sel = grp_state[g];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !stat_hit |=> (rdata == '0));
endmodule

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank
  import pclk_gate_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_PERIPH = 64,
  parameter int NUM_RSVD   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_PERIPH-1:0] clk_en
);
  localparam int NGRP   = grp_count(NUM_PERIPH, DATA_W);
  localparam int GIDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [NUM_PERIPH-1:0] RST_EN =
    NUM_PERIPH'((64'd1 << NUM_RSVD) - 64'd1);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_SET1  = ADDR_W'(32'h10);

  logic [NGRP-1:0]             set_grp, clr_grp;
  logic                        stat_hit;
  logic [GIDX_W-1:0]           stat_grp;
  logic [NGRP-1:0][DATA_W-1:0] grp_state;

  pclk_gate_decode #(
    .ADDR_W (ADDR_W),
    .NGRP   (NGRP),
    .GIDX_W (GIDX_W)
  ) u_dec (
    .addr     (bus_addr),
    .we       (bus_we),
    .set_grp  (set_grp),
    .clr_grp  (clr_grp),
    .stat_hit (stat_hit),
    .stat_grp (stat_grp)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pclk_gate_slice #(
      .W          (DATA_W),
      .BASE_ID    (g * DATA_W),
      .NUM_PERIPH (NUM_PERIPH),
      .NUM_RSVD   (NUM_RSVD)
    ) u_slice (
      .clk    (clk),
      .rst    (rst),
      .wr_set (set_grp[g]),
      .wr_clr (clr_grp[g]),
      .wdata  (bus_wdata),
      .state  (grp_state[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_PERIPH; i++)
      clk_en[i] = grp_state[i / DATA_W][i % DATA_W];
  end

  pclk_gate_readback #(
    .W      (DATA_W),
    .NGRP   (NGRP),
    .GIDX_W (GIDX_W)
  ) u_rb (
    .clk       (clk),
    .rst       (rst),
    .stat_hit  (stat_hit),
    .stat_grp  (stat_grp),
    .grp_state (grp_state),
    .rdata     (bus_rdata)
  );

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (clk_en == RST_EN));
  p_status_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STAT0) |=> (bus_rdata == $past(clk_en[DATA_W-1:0])));
  p_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STAT0) |=> (bus_rdata[NUM_RSVD-1:0] == '1));

  if (NUM_PERIPH > DATA_W) begin : g_hi_chk
    p_map_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_SET1 && bus_wdata[0]) |=> clk_en[DATA_W]);
  end
endmodule

// File: tb/pclk_gate_bank_test.sv
module pclk_gate_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] clk_en;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model;

  always #4 clk = ~clk;

  pclk_gate_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en)
  );

  function automatic logic [63:0] apply_write(input logic [63:0] m,
                                              input logic [7:0] a,
                                              input logic [31:0] d);
    logic [63:0] r = m;
    logic [63:0] sh;
    if (a[7:5] == 3'b000) begin
      sh = a[4] ? {d, 32'h0} : {32'h0, d};
      if (a[3:2] == 2'd0) r = r | sh;
      if (a[3:2] == 2'd1) r = r & ~sh;
    end
    r[1:0] = 2'b11;
    return r;
  endfunction

  function automatic logic [31:0] read_exp(input logic [63:0] m,
                                           input logic [7:0] a);
    if (a[7:5] != 3'b000 || a[3:2] != 2'd2) return 32'h0;
    return a[4] ? m[63:32] : m[31:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model = apply_write(model, a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    q = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] q;
    chk(req, clk_en, model);
    rd(8'h08, q); chk({req, " R4 status0"}, {32'h0, q}, {32'h0, model[31:0]});
    rd(8'h18, q); chk({req, " R5 status1"}, {32'h0, q}, {32'h0, model[63:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [7:0]  a;
    logic [31:0] d;
    void'($urandom(32'd1234));
    model = 64'h3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 clk_en after reset", clk_en, 64'h3);
    chk("R1 rdata after reset", {32'h0, bus_rdata}, 64'h0);

    // R8: idle bus changes nothing
    bus_wdata = 32'hFFFF_FFFF; bus_addr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 idle with data on bus", clk_en, model);
    bus_wdata = '0;

    // R2 / R3 directed
    wr(8'h00, 32'h0000_00F0); check_all("R2 set bank0");
    wr(8'h04, 32'h0000_0030); check_all("R3 clear bank0");
    // R5 bank1 mapping
    wr(8'h10, 32'h8000_0001); check_all("R5 set bank1");
    chk("R5 id32", {63'h0, clk_en[32]}, 64'h1);
    wr(8'h14, 32'h0000_0001); check_all("R5 clear bank1");
    // R6 reserved ids
    wr(8'h04, 32'hFFFF_FFFF); check_all("R6 clear all bank0");
    chk("R6 ids 0,1", {62'h0, clk_en[1:0]}, 64'h3);
    // R7 reads of set/clear registers and unmapped
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, q); chk("R7 read enable reg", {32'h0, q}, 64'h0);
    rd(8'h14, q); chk("R7 read disable reg", {32'h0, q}, 64'h0);
    rd(8'h0C, q); chk("R7 read 0x0C", {32'h0, q}, 64'h0);
    rd(8'h28, q); chk("R7 read alias above", {32'h0, q}, 64'h0);
    rd(8'h0B, q); chk("R7 low addr bits ignored", {32'h0, q}, {32'h0, model[31:0]});
    wr(8'h30, 32'hFFFF_FFFF); check_all("R7 write unmapped 0x30");
    wr(8'h1C, 32'hFFFF_FFFF); check_all("R7 write 0x1C");
    wr(8'h08, 32'hFFFF_FFFF); check_all("R7 write status reg");

    for (int n = 0; n < 400; n++) begin
      d = $urandom;
      case ($urandom % 8)
        0, 1: a = 8'h00;
        2, 3: a = 8'h04;
        4:    a = 8'h10;
        5:    a = 8'h14;
        6:    a = {3'($urandom % 7 + 1), 5'($urandom)};
        default: a = {4'b0000, 2'($urandom % 4) | 2'b11, 2'($urandom)};
      endcase
      wr(a, d);
      check_all("R2 R3 random");
      rd(a, q);
      chk("R7 R4 random read", {32'h0, q}, {32'h0, read_exp(model, a)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule